// File: doc/BRIEF.md
# TLB Range Invalidation Engine

This block keeps a small fully associative cache of translation entries and removes entries from it in response to a range invalidate command. Each slot records a virtual page tag (address bits 55:12), an address-space identifier, a global flag, a lookup level, a leaf flag, the granule the entry was built with, a narrow-format flag and a valid bit. A write port fills slots, and the valid bits of all slots are visible on a status vector.

A command is a packed 128-bit operand offered on a valid/ready stream input. The engine takes it only when `in_ready` is high. It registers the decoded range and then visits one slot per cycle, clearing every slot whose translation would serve an address inside the range and which passes the identifier, level-hint and granule rules. After the last slot it raises `done` for one cycle and then accepts again. Back-pressure rule: a producer holds `in_valid` and `in_op` steady until it sees the transfer, and `in_ready` stays low from the accepting edge until the cycle after `done`.

Top module: `tlb_rinv_engine`

## Requirements
- R1: After reset every valid bit reads 0, `in_ready` is 1 and `done` is 0.
- R2: A command transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle until `done` has been high for exactly one cycle, and it is high again in the cycle after `done`.
- R3: Operand fields: ASID in bits [63:48], granule code in [47:46], SCALE in [45:44], NUM in [43:39], level hint in [38:37], base page (address bits 55:12) in [107:64]. The range is base <= VA < base + (NUM+1) * 2^(5*SCALE+1) granules. It is computed without wrap, even at the top of the 56-bit space.
- R4: A slot covers a span of 2^(g + s*(3-level)) bytes aligned to its own size, where g = 12/14/16 and s = 9/11/13 for the 4 KB/16 KB/64 KB granules. The slot is a candidate only if this span overlaps the range.
- R5: A leaf slot with the global flag set is cleared whatever its ASID. Every other slot, leaf or non-leaf, is cleared only when its ASID equals the command's ASID.
- R6: Granule code 01 = 4 KB, 10 = 16 KB, 11 = 64 KB. A slot whose granule differs from the command's is left valid. Code 00 completes the walk and `done` but clears no slot.
- R7: Level hint 00 allows any level. With a hint of 1, 2 or 3, non-leaf slots are cleared only at levels strictly below that number, and leaf slots only at exactly that level.
- R8: With the 16 KB granule, hint 01 and `lpa_en` low, the hint acts as 00. With `lpa_en` high it means level 1.
- R9: A slot carrying the narrow flag is cleared only when the effective hint is 00.
- R10: A write sets the addressed slot valid with the new contents on the next edge. When it hits the slot that the walk clears in the same cycle, the write wins and the slot stays valid.
- R11: Valid bits change only through writes and walk clears. At most one bit falls per cycle, and none falls while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lpa_en | input | 1 | Large-address support enable (affects the 16 KB hint rule) |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Engine idle and able to take a command |
| in_op | input | 128 | Packed invalidate operand |
| done | output | 1 | One-cycle pulse at the end of a walk |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 4 | Slot index to write |
| wr_tag | input | 44 | Virtual page tag, address bits 55:12 |
| wr_asid | input | 16 | Address-space identifier |
| wr_global | input | 1 | Global flag |
| wr_level | input | 2 | Lookup level 0..3 |
| wr_leaf | input | 1 | 1 = final-level (leaf) entry |
| wr_gran | input | 2 | Granule code, same coding as R6 |
| wr_narrow | input | 1 | Narrow-format entry flag |
| valid_vec | output | 16 | Valid bit of every slot |

## Verification
Two functions can act in one cycle: a slot write and a walk clear aimed at the same slot. The bench provokes this by writing slot 0 in the first cycle after a command is accepted, which is the cycle the walk judges slot 0. Both the old and the new contents of that slot match the command. The expected result is that slot 0 stays valid, because the write takes priority over the clear. The scoreboard compares this outcome together with the surviving bits of all other slots.

// File: rtl/tlbr_pkg.sv
package tlbr_pkg;
  localparam int TAG_W  = 44;
  localparam int ASID_W = 16;
  localparam int PG_W   = TAG_W + 1;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [1:0]        lvl;
    logic              leaf;
    logic [1:0]        gran;
    logic              narrow;
  } tlbr_entry_t;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [1:0]        tg;
    logic [1:0]        ttl;
    logic [PG_W-1:0]   lo;
    logic [PG_W-1:0]   hi;
  } tlbr_cmd_t;

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DONE} tlbr_state_e;

  // granule size above 4 KB, in page-number bits
  function automatic logic [2:0] gran_pg_shift(input logic [1:0] g);
    case (g)
      2'b10:   return 3'd2;
      2'b11:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // address bits resolved per table level
  function automatic logic [3:0] lvl_step(input logic [1:0] g);
    case (g)
      2'b01:   return 4'd9;
      2'b10:   return 4'd11;
      2'b11:   return 4'd13;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/tlbr_cmd_decode.sv
module tlbr_cmd_decode
  import tlbr_pkg::*;
(
  input  logic [127:0] op,
  input  logic         lpa_en,
  output tlbr_cmd_t    cmd
);
  logic [TAG_W-1:0] base;
  logic [4:0]       num;
  logic [1:0]       scale;
  logic [1:0]       tg;
  logic [1:0]       ttl;
  logic [5:0]       count;
  logic [4:0]       shamt;
  logic [PG_W-1:0]  span;

  always_comb begin
    base  = op[107:64];
    num   = op[43:39];
    scale = op[45:44];
    tg    = op[47:46];
    ttl   = op[38:37];
    count = {1'b0, num} + 6'd1;
    // 5*scale + 1 granules exponent, converted to 4 KB pages
    shamt = 5'({scale, 2'b00}) + 5'(scale) + 5'd1 + 5'(gran_pg_shift(tg));
    span  = PG_W'(count) << shamt;

    cmd.asid = op[63:48];
    cmd.tg   = tg;
    cmd.ttl  = (tg == 2'b10 && ttl == 2'b01 && !lpa_en) ? 2'b00 : ttl;
    cmd.lo   = {1'b0, base};
    cmd.hi   = {1'b0, base} + span;
  end
endmodule

// File: rtl/tlbr_entry_match.sv
module tlbr_entry_match
  import tlbr_pkg::*;
(
  input  tlbr_entry_t ent,
  input  logic        ent_valid,
  input  tlbr_cmd_t   cmd,
  output logic        hit
);
  logic [5:0]      esh;
  logic [PG_W-1:0] esize;
  logic [PG_W-1:0] estart;
  logic [PG_W-1:0] eend;
  logic            overlap;
  logic            level_ok;
  logic            asid_ok;
  logic            gran_ok;

  always_comb begin
    esh    = 6'(gran_pg_shift(ent.gran)) + 6'(lvl_step(ent.gran)) * 6'(2'd3 - ent.lvl);
    esize  = PG_W'(1) << esh;
    estart = {1'b0, ent.tag} & ~(esize - PG_W'(1));
    eend   = estart + esize;
    overlap = (estart < cmd.hi) && (eend > cmd.lo);

    if (cmd.ttl == 2'b00)  level_ok = 1'b1;
    else if (ent.narrow)   level_ok = 1'b0;
    else if (ent.leaf)     level_ok = (ent.lvl == cmd.ttl);
    else                   level_ok = (ent.lvl < cmd.ttl);

    asid_ok = (ent.leaf && ent.glob) || (ent.asid == cmd.asid);
    gran_ok = (cmd.tg != 2'b00) && (ent.gran == cmd.tg);

    hit = ent_valid && gran_ok && overlap && level_ok && asid_ok;
  end
endmodule

// File: rtl/tlbr_entry_store.sv
module tlbr_entry_store
  import tlbr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  tlbr_entry_t        wr_ent,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic [IDX_W-1:0]   rd_idx,
  output tlbr_entry_t        rd_ent,
  output logic               rd_valid,
  output logic [ENTRIES-1:0] vld
);
  tlbr_entry_t mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_ent;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                   vld[g] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(g))        vld[g] <= 1'b1;  // write wins
      else if (clr_en && clr_idx == IDX_W'(g))      vld[g] <= 1'b0;
    end
  end

  assign rd_ent   = mem[rd_idx];
  assign rd_valid = vld[rd_idx];
endmodule

// File: rtl/tlb_rinv_engine.sv
module tlb_rinv_engine
  import tlbr_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lpa_en,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [127:0]             in_op,
  output logic                     done,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [tlbr_pkg::TAG_W-1:0]  wr_tag,
  input  logic [tlbr_pkg::ASID_W-1:0] wr_asid,
  input  logic                     wr_global,
  input  logic [1:0]               wr_level,
  input  logic                     wr_leaf,
  input  logic [1:0]               wr_gran,
  input  logic                     wr_narrow,
  output logic [ENTRIES-1:0]       valid_vec
);
  tlbr_state_e      state;
  logic [IDX_W-1:0] idx;
  tlbr_cmd_t        cmd_d;
  tlbr_cmd_t        cmd_q;
  tlbr_entry_t      wr_ent;
  tlbr_entry_t      cur_ent;
  logic             cur_valid;
  logic             hit;
  logic             clr_en;
  logic             accept;
  logic             last;

  assign wr_ent = '{tag: wr_tag, asid: wr_asid, glob: wr_global, lvl: wr_level,
                    leaf: wr_leaf, gran: wr_gran, narrow: wr_narrow};

  tlbr_cmd_decode u_dec (
    .op     (in_op),
    .lpa_en (lpa_en),
    .cmd    (cmd_d)
  );

  tlbr_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_ent   (wr_ent),
    .clr_en   (clr_en),
    .clr_idx  (idx),
    .rd_idx   (idx),
    .rd_ent   (cur_ent),
    .rd_valid (cur_valid),
    .vld      (valid_vec)
  );

  tlbr_entry_match u_match (
    .ent       (cur_ent),
    .ent_valid (cur_valid),
    .cmd       (cmd_q),
    .hit       (hit)
  );

  assign in_ready = (state == S_IDLE);
  assign done     = (state == S_DONE);
  assign accept   = in_valid && in_ready;
  assign last     = (idx == IDX_W'(ENTRIES - 1));
  assign clr_en   = (state == S_WALK) && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      cmd_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          cmd_q <= cmd_d;
          idx   <= '0;
          state <= S_WALK;
        end
        S_WALK: begin
          if (last) state <= S_DONE;
          else      idx   <= idx + IDX_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlbr_checker.sv
module tlbr_checker #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               done,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [ENTRIES-1:0] valid_vec
);
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  assert_write_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_vec[$past(wr_idx)]);

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !wr_en) |=> $stable(valid_vec));

  assert_one_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones($past(valid_vec) & ~valid_vec) <= 1));
endmodule

bind tlb_rinv_engine tlbr_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .done      (done),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .valid_vec (valid_vec)
);

// File: tb/tlb_rinv_engine_tb_top.sv
module tlb_rinv_engine_tb_top;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lpa_en = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_op = '0;
  logic         done;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_idx = '0;
  logic [43:0]  wr_tag = '0;
  logic [15:0]  wr_asid = '0;
  logic         wr_global = 1'b0;
  logic [1:0]   wr_level = '0;
  logic         wr_leaf = 1'b0;
  logic [1:0]   wr_gran = '0;
  logic         wr_narrow = 1'b0;
  logic [N-1:0] valid_vec;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  tlb_rinv_engine #(.ENTRIES(N)) dut_i (.*);

  // reference model
  longint m_tag [N];
  int     m_asid [N];
  bit     m_glob [N], m_leaf [N], m_narrow [N], m_v [N];
  int     m_lvl [N], m_gran [N];
  string  m_req [N];

  logic [N-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_hit(input int i, input logic [127:0] op, input bit lpa);
    longint lo, hi, esz, es;
    int tg, ttl, scale, num, cas, gp, eg, st;
    tg = op[47:46]; ttl = op[38:37]; scale = op[45:44]; num = op[43:39]; cas = op[63:48];
    if (!m_v[i] || tg == 0 || m_gran[i] != tg) return 0;
    if (tg == 2 && ttl == 1 && !lpa) ttl = 0;
    gp = (tg == 1) ? 0 : (tg == 2) ? 2 : 4;
    lo = longint'(op[107:64]);
    hi = lo + longint'(num + 1) * (longint'(1) << (5 * scale + 1)) * (longint'(1) << gp);
    eg = (m_gran[i] == 1) ? 0 : (m_gran[i] == 2) ? 2 : 4;
    st = (m_gran[i] == 1) ? 9 : (m_gran[i] == 2) ? 11 : 13;
    esz = longint'(1) << (eg + st * (3 - m_lvl[i]));
    es = m_tag[i] - (m_tag[i] % esz);
    if (!(es < hi && es + esz > lo)) return 0;
    if (ttl != 0) begin
      if (m_narrow[i]) return 0;
      if (m_leaf[i] && m_lvl[i] != ttl) return 0;
      if (!m_leaf[i] && m_lvl[i] >= ttl) return 0;
    end
    if (!(m_leaf[i] && m_glob[i]) && m_asid[i] != cas) return 0;
    return 1;
  endfunction

  function automatic logic [127:0] mk_op(input longint base, input int asid, input int tg,
                                         input int scale, input int num, input int ttl);
    logic [127:0] op;
    op = '0;
    op[107:64] = base[43:0];
    op[63:48]  = asid[15:0];
    op[47:46]  = tg[1:0];
    op[45:44]  = scale[1:0];
    op[43:39]  = num[4:0];
    op[38:37]  = ttl[1:0];
    return op;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    @(negedge clk);
    check(valid_vec == '0, "R1", "valid_vec after reset", longint'(valid_vec), 0);
    check(in_ready && !done, "R1", "ready/done after reset", {in_ready, done}, 2);
  endtask

  task automatic put_wr(input int i, input longint tag, input int asid, input bit g,
                        input int lvl, input bit leaf, input int gran, input bit nar);
    wr_en = 1'b1; wr_idx = 4'(i); wr_tag = tag[43:0]; wr_asid = asid[15:0];
    wr_global = g; wr_level = lvl[1:0]; wr_leaf = leaf; wr_gran = gran[1:0]; wr_narrow = nar;
  endtask

  task automatic model_set(input int i, input longint tag, input int asid, input bit g,
                           input int lvl, input bit leaf, input int gran, input bit nar,
                           input string req);
    m_tag[i] = tag; m_asid[i] = asid; m_glob[i] = g; m_lvl[i] = lvl;
    m_leaf[i] = leaf; m_gran[i] = gran; m_narrow[i] = nar; m_v[i] = 1; m_req[i] = req;
  endtask

  task automatic load(input int i, input longint tag, input int asid, input bit g,
                      input int lvl, input bit leaf, input int gran, input bit nar,
                      input string req);
    @(negedge clk);
    put_wr(i, tag, asid, g, lvl, leaf, gran, nar);
    model_set(i, tag, asid, g, lvl, leaf, gran, nar, req);
    @(negedge clk);
    wr_en = 1'b0;
    check(valid_vec[i] == 1'b1, "R10", "write sets valid", valid_vec[i], 1);
  endtask

  // driver: push expected survivors, run the handshake, optionally collide a write
  task automatic issue(input logic [127:0] op, input bit lpa, input bit collide);
    logic [N-1:0] e;
    @(negedge clk);
    for (int i = 0; i < N; i++) e[i] = m_v[i] && !model_hit(i, op, lpa);
    if (collide) e[0] = 1'b1;
    exp_q.push_back(e);
    for (int i = 0; i < N; i++) m_v[i] = e[i];
    lpa_en = lpa; in_op = op; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    if (collide) begin
      // slot 0 is judged in this cycle; the write must win (R10)
      put_wr(0, 44'h100, 5, 1'b0, 3, 1'b1, 1, 1'b0);
      model_set(0, 44'h100, 5, 1'b0, 3, 1'b1, 1, 1'b0, "R10");
      @(posedge clk);
      #1;
      wr_en = 1'b0;
    end
    forever begin
      @(negedge clk);
      if (done) break;
      check(!in_ready, "R2", "in_ready low during walk", in_ready, 0);
    end
    @(negedge clk);
    check(in_ready && !done, "R2", "ready back after done", {in_ready, done}, 2);
  endtask

  // monitor: pops expected survivors when the walk ends
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected done", 1, 0);
      end else begin
        logic [N-1:0] e;
        e = exp_q.pop_front();
        for (int i = 0; i < N; i++)
          check(valid_vec[i] == e[i], (m_req[i] == "") ? "R4" : m_req[i],
                $sformatf("slot %0d valid", i), valid_vec[i], e[i]);
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(0, "R2", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();

    // A: 4 KB, any level, range pages [0x100,0x102)
    load(0, 44'h100, 5, 0, 3, 1, 1, 0, "R4");
    load(1, 44'h101, 7, 0, 3, 1, 1, 0, "R5");
    load(2, 44'h101, 7, 1, 3, 1, 1, 0, "R5");
    load(3, 44'h102, 5, 0, 3, 1, 1, 0, "R4");
    load(4, 44'h0,   5, 0, 2, 1, 1, 0, "R4");
    load(5, 44'h0,   9, 1, 1, 0, 1, 0, "R5");
    load(6, 44'h100, 5, 0, 3, 1, 2, 0, "R6");
    load(7, 44'h100, 5, 0, 3, 1, 1, 1, "R9");
    load(8, 44'hFF,  5, 0, 3, 1, 1, 0, "R4");
    issue(mk_op(44'h100, 5, 1, 0, 0, 0), 0, 0);

    // B: level hint 3
    do_reset();
    load(0, 44'h100, 5, 0, 3, 1, 1, 0, "R7");
    load(1, 44'h0,   5, 0, 2, 1, 1, 0, "R7");
    load(2, 44'h0,   5, 0, 2, 0, 1, 0, "R7");
    load(3, 44'h100, 5, 0, 3, 0, 1, 0, "R7");
    load(4, 44'h100, 5, 0, 3, 1, 1, 1, "R9");
    issue(mk_op(44'h100, 5, 1, 0, 0, 3), 0, 0);

    // C: reserved granule clears nothing
    issue(mk_op(44'h0, 5, 0, 3, 31, 0), 0, 0);

    // D: 16 KB, hint 01, large-address disabled then enabled
    do_reset();
    load(0, 44'h400, 5, 0, 3, 1, 2, 0, "R8");
    load(1, 44'h0,   5, 0, 1, 0, 2, 0, "R8");
    issue(mk_op(44'h400, 5, 2, 0, 0, 1), 1, 0);
    issue(mk_op(44'h400, 5, 2, 0, 0, 1), 0, 0);

    // E: scale/num decode, 4 KB, [0x1000,0x1100), plus top of address space
    do_reset();
    load(0, 44'h1000, 3, 0, 3, 1, 1, 0, "R3");
    load(1, 44'h10FF, 3, 0, 3, 1, 1, 0, "R3");
    load(2, 44'h1100, 3, 0, 3, 1, 1, 0, "R3");
    load(3, 44'hFFF_FFFF_FFFF, 3, 0, 3, 1, 1, 0, "R3");
    issue(mk_op(44'h1000, 3, 1, 1, 3, 0), 0, 0);
    issue(mk_op(44'hFFF_FFFF_FF00, 3, 1, 3, 31, 0), 0, 0);

    // F: 64 KB, [0x2000,0x2040)
    do_reset();
    load(0, 44'h2030, 4, 0, 3, 1, 3, 0, "R3");
    load(1, 44'h2040, 4, 0, 3, 1, 3, 0, "R3");
    issue(mk_op(44'h2000, 4, 3, 0, 1, 0), 0, 0);

    // G: write and clear of slot 0 in the same cycle
    do_reset();
    load(0, 44'h100, 5, 0, 3, 1, 1, 0, "R10");
    load(1, 44'h100, 5, 0, 3, 1, 1, 0, "R4");
    issue(mk_op(44'h100, 5, 1, 0, 0, 0), 0, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2", "all walks completed", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule